// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the clock line waveform of an I2C master. It keeps a high count and a low count for each of three bus speeds (standard, fast and high speed), all in cycles of the controller clock. When a START is requested, it times the START hold with the line released. It then alternates low and high phases for as long as the controller stays enabled.

The low phase is timed from the cycle in which the block pulls the line down, so the fall time is part of the low period. The high phase counts only the cycles in which the sampled line reads high. A target that stretches the clock therefore lengthens the period. Two single-cycle strobes mark where the data line may change (just after a low phase ends) and where it should be sampled (in the middle of a high phase).

The count registers can be written only while the controller is disabled. The speed is chosen when a START is accepted and is held until the next START. A build without high-speed support falls back to the fast pair.

Top module: `scl_period_gen`

## Requirements
- R1: After synchronous reset the line is released, both strobes are low, and the counts hold their parameter defaults.
- R2: `cfg_sel` addresses the six count registers. Bits [2:1] pick the pair (0 standard, 1 fast, 2 high speed, 3 none). Bit 0 picks low (1) or high (0). A write is taken only while `en` is 0; a write while `en` is 1 has no effect.
- R3: `mode_req` value 0 selects the standard pair, 1 the fast pair, and 2 or 3 the high-speed pair. It is sampled only in the cycle a START is accepted; later changes do not affect the transfer in progress.
- R4: With `HS_SUPPORT` = 0, a high-speed request uses the fast pair.
- R5: A START is accepted when `en` and `start_req` are both 1 while idle. The line then stays released for exactly HCNT+3 cycles and is then driven low.
- R6: Each low phase drives the line low for exactly LCNT+1 cycles.
- R7: Each high phase ends after HCNT+8 released cycles in which `scl_in` reads 1. Released cycles with `scl_in` at 0 are not counted.
- R8: `chg_stb` pulses for one cycle, in the first released cycle after every low phase.
- R9: `smp_stb` pulses for one cycle, (HCNT+8)/2+1 counted cycles after the high phase begins counting. In released-cycle terms this is index S+(HCNT+8)/2+1, where S is the number of stretched cycles.
- R10: When `en` is 0, the next cycle releases the line and produces no strobe, and the block returns to idle. A `start_req` while disabled is not remembered.
- R11: While `en` stays 1, a high phase is followed at once by the next low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Controller enable |
| cfg_we | input | 1 | Count register write strobe |
| cfg_sel | input | 3 | Count register select |
| cfg_data | input | CNT_W | Count register write data |
| mode_req | input | 2 | Requested bus speed |
| start_req | input | 1 | Request a START and clock run |
| scl_in | input | 1 | Sampled clock line level |
| scl_low | output | 1 | 1 = pull the clock line low |
| chg_stb | output | 1 | Data change point strobe |
| smp_stb | output | 1 | Data sample point strobe |

## Verification
The bound checker watches every cycle for four things:
- each low run matches LCNT+1 of the latched pair;
- the change strobe appears only on a falling edge of the drive;
- the two strobes never coincide;
- a cleared enable releases the line with no strobe in the following cycle.

Other behaviours are shown only by the bench's scenarios. These are the START hold length, the high length under stretching, the sample strobe position, the speed latch at START, the high-speed fallback, and the ignored writes.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_HOLD,
    PH_LOW,
    PH_HIGH
  } phase_e;

  localparam int HOLD_EXTRA = 3;
  localparam int LOW_EXTRA  = 1;
  localparam int HIGH_EXTRA = 8;

  // speed request -> register pair index (0 std, 1 fast, 2 high speed)
  function automatic logic [1:0] pair_of(input logic [1:0] m);
    return m[1] ? 2'd2 : m;
  endfunction

endpackage

// File: rtl/scl_cnt_bank.sv
module scl_cnt_bank import scl_gen_pkg::*; #(
  parameter int CNT_W      = 16,
  parameter bit HS_SUPPORT = 1'b1,
  parameter logic [CNT_W-1:0] STD_HI = 16'd40,
  parameter logic [CNT_W-1:0] STD_LO = 16'd47,
  parameter logic [CNT_W-1:0] FST_HI = 16'd6,
  parameter logic [CNT_W-1:0] FST_LO = 16'd13,
  parameter logic [CNT_W-1:0] HS_HI  = 16'd2,
  parameter logic [CNT_W-1:0] HS_LO  = 16'd3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       mode_req,
  input  logic             latch,
  output logic [CNT_W-1:0] hcnt,
  output logic [CNT_W-1:0] lcnt
);

  localparam int NPAIR = 3;
  localparam logic [CNT_W-1:0] RST_HI [NPAIR] = '{STD_HI, FST_HI, HS_HI};
  localparam logic [CNT_W-1:0] RST_LO [NPAIR] = '{STD_LO, FST_LO, HS_LO};

  logic [CNT_W-1:0] hi_q [NPAIR];
  logic [CNT_W-1:0] lo_q [NPAIR];
  logic [1:0]       pair_req;
  logic [1:0]       pair_q;
  logic             wr_ok;

  assign wr_ok = wr_en && !en;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    always_ff @(posedge clk) begin
      if (rst) begin
        hi_q[p] <= RST_HI[p];
        lo_q[p] <= RST_LO[p];
      end else if (wr_ok && (wr_sel[2:1] == 2'(p))) begin
        if (wr_sel[0]) lo_q[p] <= wr_data;
        else           hi_q[p] <= wr_data;
      end
    end
  end

  if (HS_SUPPORT) begin : g_hs
    assign pair_req = pair_of(mode_req);
  end else begin : g_nohs
    assign pair_req = (pair_of(mode_req) == 2'd2) ? 2'd1 : pair_of(mode_req);
  end

  always_ff @(posedge clk) begin
    if (rst)        pair_q <= 2'd0;
    else if (latch) pair_q <= pair_req;
  end

  always_comb begin
    unique case (pair_q)
      2'd0:    begin hcnt = hi_q[0]; lcnt = lo_q[0]; end
      2'd1:    begin hcnt = hi_q[1]; lcnt = lo_q[1]; end
      default: begin hcnt = hi_q[2]; lcnt = lo_q[2]; end
    endcase
  end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm import scl_gen_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start_req,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] hcnt,
  input  logic [CNT_W-1:0] lcnt,
  output logic             start_take,
  output logic             scl_low,
  output logic             chg_stb,
  output logic             smp_stb
);

  localparam int CW = CNT_W + 1;

  phase_e        state_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] hold_len, low_len, high_len;
  logic          low_q, chg_q, smp_q;

  assign hold_len = CW'(hcnt) + CW'(HOLD_EXTRA);
  assign low_len  = CW'(lcnt) + CW'(LOW_EXTRA);
  assign high_len = CW'(hcnt) + CW'(HIGH_EXTRA);

  assign start_take = en && start_req && (state_q == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      low_q   <= 1'b0;
      chg_q   <= 1'b0;
      smp_q   <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      smp_q <= 1'b0;
      if (!en) begin
        state_q <= PH_IDLE;
        cnt_q   <= '0;
        low_q   <= 1'b0;
      end else begin
        unique case (state_q)
          PH_IDLE: begin
            if (start_req) begin
              state_q <= PH_HOLD;
              cnt_q   <= '0;
            end
          end
          PH_HOLD: begin
            if (cnt_q == hold_len - 1'b1) begin
              state_q <= PH_LOW;
              cnt_q   <= '0;
              low_q   <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_LOW: begin
            if (cnt_q == low_len - 1'b1) begin
              state_q <= PH_HIGH;
              cnt_q   <= '0;
              low_q   <= 1'b0;
              chg_q   <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_HIGH: begin
            if (scl_in) begin
              if (cnt_q == (high_len >> 1)) smp_q <= 1'b1;
              if (cnt_q == high_len - 1'b1) begin
                state_q <= PH_LOW;
                cnt_q   <= '0;
                low_q   <= 1'b1;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          default: state_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign scl_low = low_q;
  assign chg_stb = chg_q;
  assign smp_stb = smp_q;

endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen import scl_gen_pkg::*; #(
  parameter int CNT_W      = 16,
  parameter bit HS_SUPPORT = 1'b1,
  parameter logic [CNT_W-1:0] STD_HI = 16'd40,
  parameter logic [CNT_W-1:0] STD_LO = 16'd47,
  parameter logic [CNT_W-1:0] FST_HI = 16'd6,
  parameter logic [CNT_W-1:0] FST_LO = 16'd13,
  parameter logic [CNT_W-1:0] HS_HI  = 16'd2,
  parameter logic [CNT_W-1:0] HS_LO  = 16'd3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [CNT_W-1:0] cfg_data,
  input  logic [1:0]       mode_req,
  input  logic             start_req,
  input  logic             scl_in,
  output logic             scl_low,
  output logic             chg_stb,
  output logic             smp_stb
);

  logic [CNT_W-1:0] hcnt_act;
  logic [CNT_W-1:0] lcnt_act;
  logic             start_take;

  scl_cnt_bank #(
    .CNT_W(CNT_W), .HS_SUPPORT(HS_SUPPORT),
    .STD_HI(STD_HI), .STD_LO(STD_LO), .FST_HI(FST_HI),
    .FST_LO(FST_LO), .HS_HI(HS_HI), .HS_LO(HS_LO)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .wr_en    (cfg_we),
    .wr_sel   (cfg_sel),
    .wr_data  (cfg_data),
    .mode_req (mode_req),
    .latch    (start_take),
    .hcnt     (hcnt_act),
    .lcnt     (lcnt_act)
  );

  scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .start_req  (start_req),
    .scl_in     (scl_in),
    .hcnt       (hcnt_act),
    .lcnt       (lcnt_act),
    .start_take (start_take),
    .scl_low    (scl_low),
    .chg_stb    (chg_stb),
    .smp_stb    (smp_stb)
  );

endmodule

// File: rtl/scl_period_gen_chk.sv
module scl_period_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             scl_low,
  input logic             chg_stb,
  input logic             smp_stb,
  input logic [CNT_W-1:0] lcnt_act
);

  logic [CNT_W:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)          run_q <= '0;
    else if (scl_low) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  // R6
  low_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(scl_low) && en && $past(en)) |-> (run_q == ({1'b0, lcnt_act} + 1'b1)));

  // R8
  chg_edge_chk: assert property (@(posedge clk) disable iff (rst)
    chg_stb |-> $fell(scl_low));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({chg_stb, smp_stb}));

  // R10
  dis_release_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!scl_low && !chg_stb && !smp_stb));

endmodule

bind scl_period_gen scl_period_gen_chk #(.CNT_W(CNT_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .scl_low  (scl_low),
  .chg_stb  (chg_stb),
  .smp_stb  (smp_stb),
  .lcnt_act (lcnt_act)
);

// File: tb/test_scl_period_gen.sv
module test_scl_period_gen;

  localparam int CLK_PERIOD = 10;
  localparam int D_STD_HI = 5;
  localparam int D_STD_LO = 9;

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] h;
    logic [15:0] l;
    logic [7:0]  s;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{mode: 2'd0, h: 16'd10, l: 16'd12, s: 8'd0},
    '{mode: 2'd1, h: 16'd4,  l: 16'd6,  s: 8'd3},
    '{mode: 2'd2, h: 16'd0,  l: 16'd0,  s: 8'd0},
    '{mode: 2'd3, h: 16'd2,  l: 16'd1,  s: 8'd5},
    '{mode: 2'd1, h: 16'd20, l: 16'd3,  s: 8'd0},
    '{mode: 2'd0, h: 16'd7,  l: 16'd30, s: 8'd2}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [15:0] cfg_data = '0;
  logic [1:0] mode_req = '0;
  logic start_req = 1'b0;
  logic scl_in;
  logic low_a, chg_a, smp_a, low_b, chg_b, smp_b;
  logic use_b = 1'b0;
  logic m_low, m_chg, m_smp;
  int   stretch_req = 0;
  int   stretch_cnt = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_period_gen #(.STD_HI(16'(D_STD_HI)), .STD_LO(16'(D_STD_LO))) i_scl_period_gen (
    .clk(clk), .rst(rst), .en(en), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .mode_req(mode_req), .start_req(start_req),
    .scl_in(scl_in), .scl_low(low_a), .chg_stb(chg_a), .smp_stb(smp_a)
  );

  scl_period_gen #(.HS_SUPPORT(1'b0), .STD_HI(16'(D_STD_HI)), .STD_LO(16'(D_STD_LO)))
  i_scl_period_gen_nohs (
    .clk(clk), .rst(rst), .en(en), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .mode_req(mode_req), .start_req(start_req),
    .scl_in(scl_in), .scl_low(low_b), .chg_stb(chg_b), .smp_stb(smp_b)
  );

  assign m_low  = use_b ? low_b : low_a;
  assign m_chg  = use_b ? chg_b : chg_a;
  assign m_smp  = use_b ? smp_b : smp_a;
  assign scl_in = !m_low && (stretch_cnt == 0);

  // a target holding the line low for stretch_req cycles after each low phase
  always @(posedge clk) begin
    if (m_low)                stretch_cnt <= stretch_req;
    else if (stretch_cnt > 0) stretch_cnt <= stretch_cnt - 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = 16'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // START, then measure hold, low, released, next low; ends with en cleared
  task automatic run_xfer(input logic [1:0] mode_after, output int hold,
                          output int lo1, output int hi, output int chg_i,
                          output int smp_i, output int lo2);
    int g;
    hold = 0; lo1 = 0; hi = 0; lo2 = 0; chg_i = -1; smp_i = -1;
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    mode_req  = mode_after;
    g = 0;
    while (!m_low && g < 3000) begin hold++; g++; @(negedge clk); end
    while (m_low && g < 3000) begin lo1++; g++; @(negedge clk); end
    while (!m_low && g < 3000) begin
      if (m_chg && chg_i < 0) chg_i = hi;
      if (m_smp && smp_i < 0) smp_i = hi;
      hi++; g++; @(negedge clk);
    end
    while (m_low && g < 3000) begin lo2++; g++; @(negedge clk); end
    en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int hold, lo1, hi, ci, si, lo2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 scl_low", int'(low_a), 0);
    chk("R1 chg_stb", int'(chg_a), 0);
    chk("R1 smp_stb", int'(smp_a), 0);

    // R1 default counts, standard pair
    en = 1'b1; mode_req = 2'd0;
    @(negedge clk);
    run_xfer(2'd0, hold, lo1, hi, ci, si, lo2);
    chk("R1 default hold", hold, D_STD_HI + 3);
    chk("R1 default low", lo1, D_STD_LO + 1);

    // R2 write while enabled is ignored
    en = 1'b1;
    wr(3'd0, 50);
    wr(3'd1, 50);
    run_xfer(2'd0, hold, lo1, hi, ci, si, lo2);
    chk("R2 ignored hi write", hold, D_STD_HI + 3);
    chk("R2 ignored lo write", lo1, D_STD_LO + 1);

    // vector table: R3 R5 R6 R7 R8 R9 R11
    for (int v = 0; v < NVEC; v++) begin
      int pr, h, l, s;
      logic [1:0] after;
      h  = int'(VECS[v].h); l = int'(VECS[v].l); s = int'(VECS[v].s);
      pr = VECS[v].mode[1] ? 2 : int'(VECS[v].mode);
      after = (pr == 0) ? 2'd1 : 2'd0;
      en = 1'b0;
      wr(3'(pr * 2), h);
      wr(3'(pr * 2 + 1), l);
      stretch_req = s;
      mode_req = VECS[v].mode;
      en = 1'b1;
      @(negedge clk);
      run_xfer(after, hold, lo1, hi, ci, si, lo2);
      stretch_req = 0;
      chk("R5 start hold", hold, h + 3);
      chk("R6 low phase", lo1, l + 1);
      chk("R7 high phase with stretch", hi, h + 8 + s);
      chk("R8 change strobe index", ci, 0);
      chk("R9 sample strobe index", si, s + (h + 8) / 2 + 1);
      chk("R11 R3 next low latched", lo2, l + 1);
    end

    // R4 high-speed fallback, R3 codes 2 vs fast
    en = 1'b0;
    wr(3'd2, 4); wr(3'd3, 2); wr(3'd4, 11); wr(3'd5, 6);
    mode_req = 2'd2; use_b = 1'b1; en = 1'b1;
    @(negedge clk);
    run_xfer(2'd2, hold, lo1, hi, ci, si, lo2);
    chk("R4 fallback hold", hold, 4 + 3);
    chk("R4 fallback low", lo1, 2 + 1);
    use_b = 1'b0; en = 1'b1;
    @(negedge clk);
    run_xfer(2'd2, hold, lo1, hi, ci, si, lo2);
    chk("R3 high speed hold", hold, 11 + 3);
    chk("R3 high speed low", lo1, 6 + 1);

    // R10 enable cleared during low phase
    mode_req = 2'd0; en = 1'b1;
    @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    for (int k = 0; k < 200 && !low_a; k++) @(negedge clk);
    @(negedge clk);
    chk("R10 low reached", int'(low_a), 1);
    en = 1'b0;
    @(negedge clk);
    chk("R10 released after disable", int'(low_a), 0);
    chk("R10 no strobe after disable", int'(chg_a | smp_a), 0);

    // R10 start request while disabled is dropped
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    en = 1'b1;
    begin
      int lows = 0;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (low_a) lows++;
      end
      chk("R10 start while disabled ignored", lows, 0);
    end
    en = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule